// File: doc/BRIEF.md
# Ethernet Transmit Frame Formatter

This block turns a stream of payload bytes, marked with start and end flags, into a complete Ethernet frame on a byte-wide transmit output. Each frame opens with a run of 0x55 preamble bytes and one 0xD5 start-of-frame delimiter. The preamble length is programmable. The payload follows unchanged. A two-bit format code then decides what closes the frame. The frame can end at the last payload byte, because the payload already carries its own check sequence. It can gain a CRC-32 check sequence. It can first be padded with zero bytes to the Ethernet minimum and then gain the CRC.

The upstream side is a valid/ready byte interface. `in_ready` is high only while payload is being forwarded, so the source is held off during the preamble, the padding and the check sequence. The downstream side is a registered byte with a valid strobe. After every frame a fixed idle window holds the output quiet before the next frame may start. Format and preamble length are captured when a frame starts, so software may change them at any time.

Top module: `eth_tx_framer`

## Requirements
- R1: After reset the block is idle: `out_valid` is 0, and `in_ready` is 0 while no stray byte is offered.
- R2: A frame starts when `in_valid` and `in_first` are both high while the block is idle. It opens with N bytes of 0x55, where N is the value of `cfg_pre_len`, and then exactly one 0xD5 byte.
- R3: A `cfg_pre_len` of 0 is treated as a preamble of 7 bytes.
- R4: After the 0xD5 byte, every payload byte accepted (`in_valid` and `in_ready` high at a clock edge) appears on `out_data` at the next edge, unchanged and in order. `in_ready` is high only in this payload phase, apart from the stray-byte case of R10.
- R5: With `cfg_mode` = 2'b00 (pass-through), the frame ends with the byte that carried `in_last`. Nothing is appended.
- R6: With `cfg_mode` = 2'b01, four check bytes follow the last payload byte. They hold the IEEE 802.3 CRC-32 over the payload: reflected polynomial 0xEDB88320, start value 0xFFFFFFFF, result inverted. The least significant byte is sent first.
- R7: With `cfg_mode` = 2'b10 or 2'b11, a payload shorter than 60 bytes is followed by 0x00 bytes until 60 bytes have been sent. The CRC of R6 covers the payload and the pad, so the frame from the destination field to the end of the check sequence is at least 64 bytes. A payload of 60 bytes or more gets no pad.
- R8: `cfg_mode` and `cfg_pre_len` are captured in the cycle a frame starts. A change made later in that frame takes effect only from the next frame.
- R9: Between the last byte of one frame and the first preamble byte of the next, `out_valid` stays low for at least 12 cycles.
- R10: A byte offered while idle with `in_first` low is accepted and dropped. It produces no output and does not disturb the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 2 | Format code: 00 pass-through, 01 append CRC, 10/11 pad then append CRC |
| cfg_pre_len | input | PRE_W (4) | Preamble length in bytes; 0 selects 7 |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte is valid |
| in_first | input | 1 | Byte is the first of a frame |
| in_last | input | 1 | Byte is the last of a frame |
| in_ready | output | 1 | Block takes the offered byte at this edge |
| out_data | output | 8 | Transmit byte |
| out_valid | output | 1 | Transmit byte is valid |

## Verification
The output register puts one edge between every decision and the port. A preamble, pad or check byte chosen in a state cycle shows on `out_data` one cycle later. An accepted payload byte shows at the edge after the one that accepted it. The first 0x55 appears two edges after the start condition is seen. The bench never predicts these cycles directly. Its driver queues the expected bytes in order. The monitor samples at the falling edge and compares every valid byte as it arrives, so stalls and the preamble wait cannot shift a comparison. At each frame end the monitor counts falling-edge samples with `out_valid` low and requires 12 of them before any further valid byte.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  typedef enum logic [1:0] {
    FMT_PASS    = 2'b00,
    FMT_CRC     = 2'b01,
    FMT_PAD     = 2'b10,
    FMT_PAD_ALT = 2'b11
  } fmt_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_SFD,
    S_BODY,
    S_PAD,
    S_FCS,
    S_GAP
  } tx_state_e;

  localparam logic [7:0]  PRE_OCTET = 8'h55;
  localparam logic [7:0]  SFD_OCTET = 8'hD5;
  localparam logic [7:0]  PAD_OCTET = 8'h00;
  localparam logic [31:0] CRC_POLY  = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED  = 32'hFFFFFFFF;

  // One byte of reflected CRC-32, low bit first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction

  // Check byte number idx (0 goes first) of the inverted CRC.
  function automatic logic [7:0] fcs_octet(input logic [31:0] c, input logic [1:0] idx);
    logic [31:0] f;
    f = ~c;
    return f[8*idx +: 8];
  endfunction

  // Format codes with bit 1 set add padding.
  function automatic logic fmt_pads(input fmt_e m);
    return m[1];
  endfunction

endpackage

// File: rtl/eth_tx_crc.sv
module eth_tx_crc
  import eth_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= CRC_SEED;
    else if (clr) crc <= CRC_SEED;
    else if (en)  crc <= crc32_step(crc, din);
  end

endmodule

// File: rtl/eth_tx_seq.sv
module eth_tx_seq
  import eth_tx_pkg::*;
#(
  parameter int PRE_W       = 4,
  parameter int PRE_DEFAULT = 7,
  parameter int MIN_BODY    = 60,
  parameter int GAP_CYCLES  = 12,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [PRE_W-1:0] cfg_pre_len,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic             in_last,
  output logic             in_ready,
  output tx_state_e        phase,
  output logic [1:0]       fcs_idx,
  output logic             ev_start,
  output logic             ev_accept,
  output logic             ev_frame_end
);

  localparam int GAP_W = $clog2(GAP_CYCLES + 1);
  localparam logic [GAP_W-1:0] GAP_LOAD  = GAP_W'(GAP_CYCLES);
  localparam logic [CNT_W-1:0] BODY_MIN  = CNT_W'(MIN_BODY);
  localparam logic [CNT_W-1:0] BODY_MAX  = {CNT_W{1'b1}};
  localparam logic [PRE_W-1:0] PRE_DFLT  = PRE_W'(PRE_DEFAULT);

  tx_state_e        state;
  fmt_e             mode_q;
  logic [PRE_W-1:0] pre_cnt;
  logic [CNT_W-1:0] body_cnt;
  logic [1:0]       fcs_cnt;
  logic [GAP_W-1:0] gap_cnt;
  logic [CNT_W-1:0] body_inc;
  tx_state_e        after_body;

  function automatic logic [PRE_W-1:0] eff_pre(input logic [PRE_W-1:0] l);
    return (l == '0) ? PRE_DFLT : l;
  endfunction

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == BODY_MAX) ? v : v + CNT_W'(1);
  endfunction

  function automatic logic short_body(input fmt_e m, input logic [CNT_W-1:0] n);
    return fmt_pads(m) && (n < BODY_MIN);
  endfunction

  assign phase        = state;
  assign fcs_idx      = fcs_cnt;
  assign ev_start     = (state == S_IDLE) && in_valid && in_first;
  assign ev_accept    = (state == S_BODY) && in_valid;
  assign in_ready     = (state == S_BODY) || ((state == S_IDLE) && in_valid && !in_first);
  assign body_inc     = sat_inc(body_cnt);
  assign ev_frame_end = (ev_accept && in_last && (mode_q == FMT_PASS)) ||
                        ((state == S_FCS) && (fcs_cnt == 2'd3));

  always_comb begin
    if (mode_q == FMT_PASS)              after_body = S_GAP;
    else if (short_body(mode_q, body_inc)) after_body = S_PAD;
    else                                 after_body = S_FCS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      mode_q   <= FMT_PASS;
      pre_cnt  <= '0;
      body_cnt <= '0;
      fcs_cnt  <= '0;
      gap_cnt  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (ev_start) begin
            state   <= S_PRE;
            mode_q  <= fmt_e'(cfg_mode);
            pre_cnt <= eff_pre(cfg_pre_len);
          end
        end
        S_PRE: begin
          if (pre_cnt <= PRE_W'(1)) state <= S_SFD;
          else                      pre_cnt <= pre_cnt - PRE_W'(1);
        end
        S_SFD: begin
          state    <= S_BODY;
          body_cnt <= '0;
        end
        S_BODY: begin
          if (ev_accept) begin
            body_cnt <= body_inc;
            if (in_last) begin
              state   <= after_body;
              fcs_cnt <= '0;
              gap_cnt <= GAP_LOAD;
            end
          end
        end
        S_PAD: begin
          body_cnt <= body_inc;
          if (body_inc >= BODY_MIN) state <= S_FCS;
        end
        S_FCS: begin
          fcs_cnt <= fcs_cnt + 2'd1;
          if (fcs_cnt == 2'd3) state <= S_GAP;
        end
        S_GAP: begin
          if (gap_cnt <= GAP_W'(1)) state <= S_IDLE;
          else                      gap_cnt <= gap_cnt - GAP_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
  import eth_tx_pkg::*;
#(
  parameter int PRE_W       = 4,
  parameter int PRE_DEFAULT = 7,
  parameter int MIN_FRAME   = 64,
  parameter int GAP_CYCLES  = 12,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic [PRE_W-1:0] cfg_pre_len,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic             in_last,
  output logic             in_ready,
  output logic [7:0]       out_data,
  output logic             out_valid
);

  localparam int MIN_BODY = MIN_FRAME - 4;

  tx_state_e   phase;
  logic [1:0]  fcs_idx;
  logic        ev_start;
  logic        ev_accept;
  logic        ev_frame_end;
  logic        ev_pre;
  logic        ev_pad;
  logic [31:0] crc;
  logic        crc_en;
  logic [7:0]  crc_din;
  logic [7:0]  nxt_data;
  logic        nxt_valid;

  eth_tx_seq #(
    .PRE_W      (PRE_W),
    .PRE_DEFAULT(PRE_DEFAULT),
    .MIN_BODY   (MIN_BODY),
    .GAP_CYCLES (GAP_CYCLES),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_mode    (cfg_mode),
    .cfg_pre_len (cfg_pre_len),
    .in_valid    (in_valid),
    .in_first    (in_first),
    .in_last     (in_last),
    .in_ready    (in_ready),
    .phase       (phase),
    .fcs_idx     (fcs_idx),
    .ev_start    (ev_start),
    .ev_accept   (ev_accept),
    .ev_frame_end(ev_frame_end)
  );

  assign ev_pre  = (phase == S_PRE);
  assign ev_pad  = (phase == S_PAD);
  assign crc_en  = ev_accept || ev_pad;
  assign crc_din = ev_pad ? PAD_OCTET : in_data;

  eth_tx_crc u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (ev_start),
    .en   (crc_en),
    .din  (crc_din),
    .crc  (crc)
  );

  always_comb begin
    nxt_valid = 1'b0;
    nxt_data  = 8'h00;
    case (phase)
      S_PRE:  begin nxt_valid = 1'b1;     nxt_data = PRE_OCTET; end
      S_SFD:  begin nxt_valid = 1'b1;     nxt_data = SFD_OCTET; end
      S_BODY: begin nxt_valid = in_valid; nxt_data = in_valid ? in_data : 8'h00; end
      S_PAD:  begin nxt_valid = 1'b1;     nxt_data = PAD_OCTET; end
      S_FCS:  begin nxt_valid = 1'b1;     nxt_data = fcs_octet(crc, fcs_idx); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= 8'h00;
    end else begin
      out_valid <= nxt_valid;
      out_data  <= nxt_data;
    end
  end

endmodule

// File: rtl/eth_tx_framer_chk.sv
module eth_tx_framer_chk #(
  parameter int GAP_CYCLES = 12
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] in_data,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       ev_pre,
  input logic       ev_accept,
  input logic       ev_pad,
  input logic       ev_frame_end
);

  localparam int Q_W = $clog2(GAP_CYCLES + 2) + 1;
  localparam logic [Q_W-1:0] Q_MAX = {Q_W{1'b1}};
  localparam logic [Q_W-1:0] Q_REQ = Q_W'(GAP_CYCLES);

  logic [Q_W-1:0] quiet;
  logic           end_pend;
  logic           ended;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet    <= '0;
      end_pend <= 1'b0;
      ended    <= 1'b0;
    end else begin
      quiet    <= out_valid ? '0 : ((quiet == Q_MAX) ? quiet : quiet + Q_W'(1));
      end_pend <= ev_frame_end;
      if (end_pend)       ended <= 1'b1;
      else if (out_valid) ended <= 1'b0;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);

  a_r2_pre_octet: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pre |=> (out_valid && out_data == 8'h55));

  a_r4_body_copy: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (out_valid && out_data == $past(in_data)));

  a_r7_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pad |=> (out_valid && out_data == 8'h00));

  a_r9_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (ended && $rose(out_valid)) |-> (quiet >= Q_REQ));

endmodule

bind eth_tx_framer eth_tx_framer_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_data     (in_data),
  .out_data    (out_data),
  .out_valid   (out_valid),
  .ev_pre      (ev_pre),
  .ev_accept   (ev_accept),
  .ev_pad      (ev_pad),
  .ev_frame_end(ev_frame_end)
);

// File: tb/test_eth_tx_framer.sv
`timescale 1ns/1ps
module test_eth_tx_framer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic [3:0] cfg_pre_len = 4'd7;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_first = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic [7:0] out_data;
  logic       out_valid;

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  int         len_q[$];
  string      gtag_q[$];

  always #2 clk = ~clk;

  eth_tx_framer i_eth_tx_framer (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_pre_len(cfg_pre_len),
    .in_data(in_data), .in_valid(in_valid), .in_first(in_first), .in_last(in_last),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid)
  );

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = r[0] ^ b[i];
      r = r >> 1;
      if (fb) r = r ^ 32'hEDB88320;
    end
    return r;
  endfunction

  task automatic report(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic push_exp(input logic [7:0] b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  // Offer one byte; return at the falling edge after it is taken.
  task automatic drive_byte(input logic [7:0] b, input bit first, input bit last);
    in_valid = 1'b1; in_data = b; in_first = first; in_last = last;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
  endtask

  task automatic send_frame(input int len, input logic [1:0] mode, input logic [3:0] plen,
                            input int seed, input bit swap_cfg);
    int          npre;
    int          body;
    logic [31:0] c;
    logic [7:0]  b;
    string       ptag;
    npre = (plen == 0) ? 7 : int'(plen);
    ptag = swap_cfg ? "R8" : ((plen == 0) ? "R3" : "R2");
    for (int i = 0; i < npre; i++) push_exp(8'h55, ptag);
    push_exp(8'hD5, "R2");
    c = 32'hFFFFFFFF;
    body = 0;
    for (int i = 0; i < len; i++) begin
      b = 8'((seed * 31 + i * 13 + i * i) & 255);
      push_exp(b, (mode == 2'b00) ? "R5" : "R4");
      c = ref_crc(c, b);
      body++;
    end
    if (mode[1]) begin
      while (body < 60) begin
        push_exp(8'h00, "R7");
        c = ref_crc(c, 8'h00);
        body++;
      end
    end
    if (mode != 2'b00) begin
      for (int k = 0; k < 4; k++) push_exp(8'((~c) >> (8 * k)), swap_cfg ? "R8" : "R6");
    end
    len_q.push_back(npre + 1 + body + ((mode != 2'b00) ? 4 : 0));
    gtag_q.push_back((mode == 2'b00) ? "R5" : "R9");

    @(negedge clk);
    cfg_mode = mode;
    cfg_pre_len = plen;
    for (int i = 0; i < len; i++) begin
      drive_byte(8'((seed * 31 + i * 13 + i * i) & 255), i == 0, i == len - 1);
      if (i == 0 && swap_cfg) begin
        cfg_mode = ~mode;
        cfg_pre_len = 4'd1;
      end
    end
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
  endtask

  task automatic send_stray(input logic [7:0] b);
    int waited;
    waited = 0;
    in_valid = 1'b1; in_data = b; in_first = 1'b0; in_last = 1'b0;
    #1;
    while (!in_ready && waited < 60) begin
      @(negedge clk); #1;
      waited++;
    end
    report(in_ready == 1'b1, "R10 stray byte not taken", waited, 0);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Scoreboard monitor: byte order, frame lengths, idle gap.
  int    mon_bytes = 0;
  int    idle_n = 0;
  bit    gap_watch = 1'b0;
  string gap_tag = "R9";

  always @(negedge clk) begin
    if (rst_n) begin
      if (gap_watch) begin
        if (out_valid) begin
          report(1'b0, {gap_tag, " idle gap too short"}, idle_n, 12);
          gap_watch = 1'b0;
        end else begin
          idle_n++;
          if (idle_n == 12) begin
            report(1'b1, gap_tag, idle_n, 12);
            gap_watch = 1'b0;
          end
        end
      end
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          report(1'b0, "R5 unexpected byte", int'(out_data), 0);
        end else begin
          logic [7:0] e;
          string      t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          report(out_data == e, t, int'(out_data), int'(e));
          mon_bytes++;
          if (len_q.size() != 0 && mon_bytes == len_q[0]) begin
            void'(len_q.pop_front());
            gap_tag = gtag_q.pop_front();
            mon_bytes = 0;
            idle_n = 0;
            gap_watch = 1'b1;
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    report(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    report(in_ready == 1'b0, "R1 in_ready", int'(in_ready), 0);

    send_frame(20, 2'b01, 4'd7, 1, 1'b0);  // R2 R6
    send_frame(10, 2'b10, 4'd3, 2, 1'b0);  // R7 padded
    send_frame(12, 2'b00, 4'd0, 3, 1'b0);  // R3 R5
    send_frame(70, 2'b10, 4'd5, 4, 1'b0);  // R7 no pad
    send_frame(1,  2'b11, 4'd2, 5, 1'b0);  // R7 alt code, one byte
    send_frame(16, 2'b01, 4'd4, 6, 1'b1);  // R8 config change mid-frame
    send_stray(8'hA7);                     // R10
    send_frame(60, 2'b10, 4'd15, 7, 1'b0); // R7 boundary, R10 follow-up

    repeat (200) @(negedge clk);
    report(exp_q.size() == 0, "R5 bytes left unsent", exp_q.size(), 0);
    report(len_q.size() == 0, "R9 frames unfinished", len_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule